// File: doc/BRIEF.md
# Seven-to-one pixel link serializer

This block turns a 21-bit pixel word into three serial data lanes and one forwarded clock lane. The word holds 18 colour bits (six each of red, green and blue) and three panel timing signals: line sync, frame sync and data enable. Each lane carries seven bits per pixel period. The block runs on a bit clock at seven times the pixel rate. A phase strobe marks the pixel clock's falling edge, which is also the frame boundary. The strobe is high for one bit-clock cycle in every seven. On the bit-clock edge where the strobe is high, the block samples the pixel word. On the same edge it loads the word captured one frame earlier into the lane shift registers.

The lanes leave the block as single-ended logic bits with a shared output-enable flag. The flag stands in for a high-impedance driver. A low-active power-down input drops the enable at once. After power-down is released, or after reset, the enable returns only at a frame boundary. The first word sent after that is the first word captured after the release.

Top module: `disp_ser`

## Requirements
- R1: All 21 bits of `pix_i` are sampled on the bit-clock edge where `frame_i` is high. Values on `pix_i` in the other six cycles of the frame have no effect on any output.
- R2: In slot s (s = 0..6, slot 0 being the first bit period after the load edge), data lane k (k = 0..2) carries word bit 7k+s. So `data_o[0]` sends bits 0..6, `data_o[1]` sends bits 7..13 and `data_o[2]` sends bits 14..20, lowest bit first.
- R3: A word sampled at one strobe edge is loaded at the next strobe edge. It appears in slot 0 in the bit period that follows that second edge, which is one pixel period of latency.
- R4: While enabled, `clk_lane_o` sends the values 1,1,0,0,0,1,1 in slots 0 to 6. Its only falling transition inside a frame is at the start of slot 2.
- R5: While `pd_ni` is low, `oe_o`, all of `data_o` and `clk_lane_o` are low in the same cycle, with no clock edge needed.
- R6: After `pd_ni` returns high, `oe_o` stays low until the second strobe edge seen with `pd_ni` high. It then rises at that frame boundary, and the first word sent is the one sampled at the first of those two strobe edges.
- R7: While `rst_ni` is low, `oe_o` and all lane outputs are low. After reset the block arms the same way as in R6.
- R8: Whenever `oe_o` is low, `data_o` and `clk_lane_o` are driven low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Bit clock, seven times the pixel rate |
| rst_ni | input | 1 | Active-low asynchronous reset |
| frame_i | input | 1 | Phase strobe: high for one cycle in seven, at the pixel falling edge |
| pd_ni | input | 1 | Active-low power-down |
| pix_i | input | 21 | Pixel word: red [5:0], green [11:6], blue [17:12], line sync [18], frame sync [19], data enable [20] |
| data_o | output | 3 | Serial data lanes, one bit per bit-clock cycle |
| clk_lane_o | output | 1 | Forwarded pixel clock lane |
| oe_o | output | 1 | Lane output enable; low means the lanes are disabled |

## Verification
The bench changes `pix_i` to random values between strobes. A design that sampled on the wrong edge, or sampled more than once per frame, would send those values instead of the word that was presented at the strobe. Bit-reversed or lane-swapped words and walking-one patterns expose a wrong slot order or wrong lane mapping. A clock pattern shifted by one slot shows up as a mismatch on `clk_lane_o`.

Power-down is applied for a whole frame, and also asserted and released in the middle of frames. A design that gated the enable only at frame edges would keep driving the lanes during power-down. A design that re-armed after one strobe would send a stale or undefined word in the first enabled frame.

// File: rtl/disp_ser_pkg.sv
package disp_ser_pkg;
  localparam int SER_SLOTS = 7;
  localparam int SER_LANES = 3;
  localparam logic [SER_SLOTS-1:0] SER_CLK_PAT = 7'b1100011; // bit s = slot s
endpackage

// File: rtl/disp_ser_lane.sv
module disp_ser_lane #(
  parameter int SLOTS = 7
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             load_i,
  input  logic [SLOTS-1:0] par_i,
  output logic             ser_o
);
  logic [SLOTS-1:0] sr_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     sr_q <= '0;
    else if (load_i) sr_q <= par_i;
    else             sr_q <= {1'b0, sr_q[SLOTS-1:1]};
  end

  assign ser_o = sr_q[0];
endmodule

// File: rtl/disp_ser_ctrl.sv
module disp_ser_ctrl #(
  parameter int WORD_W = 21
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              frame_i,
  input  logic              pd_ni,
  input  logic [WORD_W-1:0] pix_i,
  output logic [WORD_W-1:0] hold_o,
  output logic              load_o,
  output logic              en_o
);
  logic [WORD_W-1:0] hold_q;
  logic              cap_v_q;
  logic              en_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      hold_q  <= '0;
      cap_v_q <= 1'b0;
      en_q    <= 1'b0;
    end else if (!pd_ni) begin
      cap_v_q <= 1'b0;
      en_q    <= 1'b0;
    end else if (frame_i) begin
      hold_q  <= pix_i;
      cap_v_q <= 1'b1;
      en_q    <= cap_v_q; // enable only once a post-release word is held
    end
  end

  assign hold_o = hold_q;
  assign load_o = frame_i;
  assign en_o   = en_q;
endmodule

// File: rtl/disp_ser.sv
module disp_ser
  import disp_ser_pkg::*;
#(
  parameter int SLOTS = SER_SLOTS,
  parameter int LANES = SER_LANES,
  parameter logic [SLOTS-1:0] CLK_PAT = SER_CLK_PAT,
  localparam int WORD_W = SLOTS * LANES
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              frame_i,
  input  logic              pd_ni,
  input  logic [WORD_W-1:0] pix_i,
  output logic [LANES-1:0]  data_o,
  output logic              clk_lane_o,
  output logic              oe_o
);
  logic [WORD_W-1:0] hold;
  logic              load;
  logic              en;
  logic [LANES-1:0]  lane_raw;
  logic              clk_raw;

  disp_ser_ctrl #(.WORD_W(WORD_W)) u_ctrl (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .frame_i(frame_i),
    .pd_ni  (pd_ni),
    .pix_i  (pix_i),
    .hold_o (hold),
    .load_o (load),
    .en_o   (en)
  );

  for (genvar k = 0; k < LANES; k++) begin : g_lane
    disp_ser_lane #(.SLOTS(SLOTS)) u_lane (
      .clk_i (clk_i),
      .rst_ni(rst_ni),
      .load_i(load),
      .par_i (hold[k*SLOTS +: SLOTS]),
      .ser_o (lane_raw[k])
    );
  end

  disp_ser_lane #(.SLOTS(SLOTS)) u_clk_lane (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .load_i(load),
    .par_i (CLK_PAT),
    .ser_o (clk_raw)
  );

  // power-down gates the drivers without waiting for a clock edge
  assign oe_o       = en & pd_ni;
  assign data_o     = lane_raw & {LANES{oe_o}};
  assign clk_lane_o = clk_raw & oe_o;
endmodule

// File: rtl/disp_ser_chk.sv
module disp_ser_chk #(
  parameter int SLOTS = 7,
  parameter int LANES = 3,
  parameter logic [SLOTS-1:0] CLK_PAT = 7'b1100011,
  localparam int WORD_W = SLOTS * LANES,
  localparam int SW = $clog2(SLOTS + 1)
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              frame_i,
  input logic              pd_ni,
  input logic [WORD_W-1:0] pix_i,
  input logic [LANES-1:0]  data_o,
  input logic              clk_lane_o,
  input logic              oe_o
);
  logic [WORD_W-1:0] cap_q, sent_q;
  logic [SW-1:0]     slot_q;
  logic              seen_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cap_q  <= '0;
      sent_q <= '0;
      slot_q <= '0;
      seen_q <= 1'b0;
    end else if (frame_i) begin
      cap_q  <= pix_i;
      sent_q <= cap_q;
      slot_q <= '0;
      seen_q <= 1'b1;
    end else if (slot_q < SW'(SLOTS)) begin
      slot_q <= slot_q + 1'b1;
    end
  end

  p_pd_off_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !pd_ni |-> (!oe_o && data_o == '0 && !clk_lane_o));

  p_idle_low_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !oe_o |-> (data_o == '0 && !clk_lane_o));

  p_oe_at_boundary_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(oe_o) |-> $past(frame_i));

  p_clk_pattern_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (oe_o && seen_q && slot_q < SW'(SLOTS)) |-> clk_lane_o == CLK_PAT[slot_q]);

  for (genvar k = 0; k < LANES; k++) begin : g_chk
    // R1 R3: bit of the word captured one frame earlier
    p_lane_bit_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (oe_o && seen_q && slot_q < SW'(SLOTS)) |->
        data_o[k] == sent_q[k*SLOTS + int'(slot_q)]);
  end
endmodule

bind disp_ser disp_ser_chk #(.SLOTS(SLOTS), .LANES(LANES), .CLK_PAT(CLK_PAT)) chk_i (.*);

// File: tb/disp_ser_tb_top.sv
module disp_ser_tb_top;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        frame_i = 1'b0;
  logic        pd_ni = 1'b1;
  logic [20:0] pix_i = '0;
  logic [2:0]  data_o;
  logic        clk_lane_o;
  logic        oe_o;

  localparam logic [6:0] PAT = 7'b1100011;

  int checks = 0;
  int errors = 0;
  logic [20:0] exp_q[$];
  int   caps = 0;
  bit   frame_oe = 1'b0;
  logic [20:0] cur_word = '0;

  disp_ser dut_i (.*);

  always #5 clk_i = ~clk_i;

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  // drives one frame; pd_sched[s] is the power-down level applied at slot s
  task automatic run_frame(input logic [20:0] w, input logic [6:0] pd_sched);
    for (int s = 0; s < 7; s++) begin
      @(negedge clk_i);
      begin : monitor
        bit exp_oe;
        exp_oe = frame_oe && pd_ni;
        chk(oe_o == exp_oe, pd_ni ? "R6" : "R5", "oe_o", oe_o, exp_oe);
        for (int k = 0; k < 3; k++) begin
          logic eb;
          eb = exp_oe ? cur_word[7*k+s] : 1'b0;
          chk(data_o[k] == eb, exp_oe ? "R1 R2 R3" : "R8", "data_o bit",
              data_o[k], eb);
        end
        chk(clk_lane_o == (exp_oe ? PAT[s] : 1'b0), exp_oe ? "R4" : "R8",
            "clk_lane_o", clk_lane_o, exp_oe ? PAT[s] : 1'b0);
      end
      pd_ni   = pd_sched[s];
      frame_i = 1'b0;
      pix_i   = 21'($urandom);
      if (!pd_sched[s]) begin
        caps = 0;
        exp_q.delete();
        frame_oe = 1'b0;
      end
      if (s == 6) begin
        frame_i = 1'b1;
        pix_i   = w;
        if (pd_sched[s]) begin
          frame_oe = (caps >= 1);
          if (frame_oe) begin
            if (exp_q.size() > 0) cur_word = exp_q.pop_front();
            else chk(1'b0, "R6", "scoreboard empty", 0, 1);
          end
          exp_q.push_back(w);
          caps++;
        end else begin
          frame_oe = 1'b0;
        end
      end
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk_i);
    errors++;
    $display("FAIL watchdog expired actual=0 expected=1");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk_i);
    chk(oe_o == 1'b0, "R7", "oe_o in reset", oe_o, 0);
    chk(data_o == 3'b0 && clk_lane_o == 1'b0, "R7", "lanes in reset",
        {clk_lane_o, data_o}, 0);
    rst_ni = 1'b1;

    run_frame(21'h1FFFFF, 7'h7F);
    run_frame(21'h000000, 7'h7F);
    run_frame(21'h155555, 7'h7F);
    run_frame(21'h0AAAAA, 7'h7F);
    for (int b = 0; b < 21; b++) run_frame(21'(1) << b, 7'h7F);
    run_frame(21'h00007F, 7'h7F);
    run_frame(21'h1FC000, 7'h7F);
    // R5: full frame of power-down, then mid-frame release
    run_frame(21'h123456, 7'h00);
    run_frame(21'h0ABCDE, 7'b1111000);
    run_frame(21'h13579B, 7'h7F);
    run_frame(21'h02468A, 7'h7F);
    run_frame(21'h1C3C3C, 7'h7F);
    // R5: short pulse inside an enabled frame
    run_frame(21'h111111, 7'b1110111);
    run_frame(21'h0F0F0F, 7'h7F);
    run_frame(21'h1E1E1E, 7'h7F);
    for (int i = 0; i < 30; i++) run_frame(21'($urandom), 7'h7F);
    run_frame(21'h0, 7'h7F);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule